// File: doc/BRIEF.md
# ADC Result Register Interface

This block keeps the most recent 10-bit conversion result of an analog-to-digital converter. It presents that result to a byte-wide register bus as two read-only bytes, a low byte and a high byte. The converter sends a one-cycle completion pulse with the result code. Each pulse that is accepted stores the code unchanged. Code 0x000 stands for ground and code 0x3FF stands for the reference minus one LSB. An alignment input chooses how the 10 bits are placed in the 16-bit pair: right-adjusted (the default) or left-adjusted. In left-adjusted mode, software that needs only 8 bits of precision can read the high byte alone.

For a full-precision read, software reads the low byte first and then the high byte. Reading the low byte locks the stored result. Results that complete while the lock is held are dropped and are not queued. Each drop sets a sticky lost-result flag, which stays set until reset. Reading the high byte releases the lock. The stored value is kept unaligned and is shifted only at the read mux, so a change of the alignment input appears on the read data at once.

Top module: `adc_result_regs`

## Requirements
- R1: After reset, reads at the low address (0x04) and at the high address (0x05) both return 0x00, and the lost flag is 0.
- R2: A completion pulse stores conv_data when the lock is clear and no low-byte read happens in the same cycle. The code is stored without any change.
- R3: With left_adj = 0, the low byte holds result bits 7..0. The high byte holds result bits 9..8 in bits 1..0, and high-byte bits 7..2 read 0.
- R4: With left_adj = 1, the high byte holds result bits 9..2, so it gives the upper 8 bits with no low-byte read. The low byte holds result bits 1..0 in bits 7..6, and low-byte bits 5..0 read 0.
- R5: A read at any address other than 0x04 or 0x05, or a cycle with rd_en low, returns 0x00.
- R6: A low-byte read sets the lock. While the lock is set, completion pulses leave the stored result unchanged. A high-byte read clears the lock.
- R7: A completion pulse that is blocked sets the lost flag. The flag stays at 1 until reset.
- R8: A high-byte read with no earlier low-byte read does not set the lock. A later completion pulse is still stored.
- R9: A change of left_adj changes the placement in the read data in the same cycle, with no new conversion.
- R10: A completion pulse in the same cycle as a low-byte read is blocked. The high byte read next belongs to the same result as that low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the result, the lock and the lost flag |
| conv_done | input | 1 | One-cycle pulse: conversion complete |
| conv_data | input | 10 | Result code that goes with conv_done |
| left_adj | input | 1 | 1 = left-adjusted placement, 0 = right-adjusted |
| rd_en | input | 1 | Read strobe, one cycle per register read |
| rd_addr | input | 8 | Register address of the read |
| rd_data | output | 8 | Read data, valid in the same cycle as rd_en |
| lost | output | 1 | Sticky flag: a result was dropped because of the lock |

## Verification
The hardest case to reach is a completion pulse that arrives in the exact cycle of a low-byte read. The read returns the old byte in that cycle, and the lock is only set at the clock edge that ends it. The stimulus raises conv_done and the low-byte read strobe on the same falling edge. It then reads the high byte and expects the old result's upper bits and a set lost flag. The bench also places pulses inside an open lock, both before and after a high-only read. This shows that only the low byte opens a lock.

// File: rtl/adc_result_regs.sv
module adc_result_regs #(
  parameter int                RES_W   = 10,
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h04,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  input  logic              left_adj,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              lost
);
  localparam int PAIR_W = 16;
  localparam int PAD    = PAIR_W - RES_W;

  logic [RES_W-1:0]  res_q;
  logic              lock_q;
  logic              lost_q;
  logic [PAIR_W-1:0] pair;

  wire lo_rd   = rd_en && (rd_addr == LO_ADDR);
  wire hi_rd   = rd_en && (rd_addr == HI_ADDR);
  wire blocked = lock_q || lo_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      lock_q <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      if (conv_done && !blocked) res_q  <= conv_data;
      if (conv_done && blocked)  lost_q <= 1'b1;
      if (lo_rd)                 lock_q <= 1'b1;
      else if (hi_rd)            lock_q <= 1'b0;
    end
  end

  assign pair    = left_adj ? {res_q, {PAD{1'b0}}} : {{PAD{1'b0}}, res_q};
  assign rd_data = lo_rd ? pair[7:0] : hi_rd ? pair[15:8] : 8'h00;
  assign lost    = lost_q;
endmodule

// File: rtl/adc_result_regs_chk.sv
module adc_result_regs_chk #(
  parameter int                RES_W   = 10,
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h04,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h05
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_done,
  input logic [RES_W-1:0]  conv_data,
  input logic              left_adj,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data,
  input logic              lost,
  input logic [RES_W-1:0]  res,
  input logic              lock
);
  p_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && !lock && !(rd_en && rd_addr == LO_ADDR) |=> res == $past(conv_data));

  p_right_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_addr == HI_ADDR && !left_adj |-> (rd_data >> (RES_W - 8)) == 8'h00);

  p_other_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && (rd_addr == LO_ADDR || rd_addr == HI_ADDR)) |-> rd_data == 8'h00);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(res));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_addr == HI_ADDR |=> !lock);

  p_drop_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && lock |=> lost);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> lost);

  p_no_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lock && !(rd_en && rd_addr == LO_ADDR) |=> !lock);

  p_same_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_addr == LO_ADDR |=> $stable(res) && lock);
endmodule

bind adc_result_regs adc_result_regs_chk #(
  .RES_W(RES_W), .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
  .left_adj(left_adj), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .lost(lost), .res(res_q), .lock(lock_q)
);

// File: tb/adc_result_regs_test.sv
module adc_result_regs_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_done = 1'b0;
  logic [9:0] conv_data = '0;
  logic       left_adj = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       lost;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [7:0] q_exp[$];
  string      q_tag[$];

  adc_result_regs uut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
    .left_adj(left_adj), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .lost(lost)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: compares each read against the scoreboard
  initial forever begin
    @(negedge clk);
    #1;
    if (rd_en) begin
      if (q_exp.size() == 0) check("scoreboard underrun", 8'h01, 8'h00);
      else check(q_tag.pop_front(), rd_data, q_exp.pop_front());
    end
  end

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag, bit with_conv = 0,
                    logic [9:0] d = '0);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    if (with_conv) begin conv_done = 1'b1; conv_data = d; end
    q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0; conv_done = 1'b0;
  endtask

  task automatic conv(logic [9:0] d);
    @(negedge clk);
    conv_done = 1'b1; conv_data = d;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  initial begin
    #(PERIOD*20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(8'h04, 8'h00, "R1 low after reset");
    rd(8'h05, 8'h00, "R1 high after reset");
    @(negedge clk); check("R1 lost after reset", {7'b0, lost}, 8'h00);

    conv(10'h2B5);
    rd(8'h04, 8'hB5, "R2 R3 low right");
    rd(8'h05, 8'h02, "R3 high right");
    @(negedge clk); left_adj = 1'b1;
    rd(8'h05, 8'hAD, "R4 R9 high left alone");
    rd(8'h04, 8'h40, "R4 low left");
    rd(8'h05, 8'hAD, "R4 high left after low");
    rd(8'h06, 8'h00, "R5 other address");
    @(negedge clk); left_adj = 1'b0;
    rd(8'h05, 8'h02, "R9 back to right");

    rd(8'h04, 8'hB5, "R6 low opens lock");
    conv(10'h155);
    rd(8'h05, 8'h02, "R6 high keeps old result");
    @(negedge clk); check("R7 lost after drop", {7'b0, lost}, 8'h01);
    conv(10'h155);
    rd(8'h04, 8'h55, "R2 R6 store after release");
    rd(8'h05, 8'h01, "R2 high after release");
    @(negedge clk); check("R7 lost stays set", {7'b0, lost}, 8'h01);

    rd(8'h05, 8'h01, "R8 high only read");
    conv(10'h3FF);
    rd(8'h04, 8'hFF, "R8 store after high only");
    rd(8'h05, 8'h03, "R8 high full scale");

    rd(8'h04, 8'hFF, "R10 low with same cycle pulse", 1'b1, 10'h000);
    rd(8'h05, 8'h03, "R10 high coherent");
    @(negedge clk); left_adj = 1'b1;
    rd(8'h05, 8'hFF, "R4 R10 high left full scale");
    rd(8'h04, 8'hC0, "R4 low left full scale");
    rd(8'h05, 8'hFF, "R4 release");
    conv(10'h000);
    rd(8'h05, 8'h00, "R2 zero code high");
    rd(8'h04, 8'h00, "R2 zero code low");
    rd(8'h05, 8'h00, "R2 zero release");

    repeat (2) @(negedge clk);
    check("scoreboard drained", 8'(q_exp.size()), 8'h00);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule